// File: doc/BRIEF.md
# Two-Bank Line Prefetch Read Buffer

This block sits between a bus master's burst read and a local memory that answers whole lines with variable latency. A read request names a start address. The block fetches the line holding that address into one of two 32-byte banks, then walks through the burst one 32-bit word at a time. While one bank is drained toward the bus, the other bank is loaded from memory with the following sequential line. The two banks swap roles at every line boundary.

Each bus beat is offered with a valid/ready handshake. The byte enables given with the beat decide which byte lanes carry data. When the next word has not yet arrived from memory, valid stays low and the bus sees a wait state. A beat may be read out of a bank while the rest of that line is still arriving. Ending the burst drops everything that was prefetched. If line fetches are still in flight, their remaining words are absorbed before a new request is taken.

Top module: `pp_prefetch_buf`

## Requirements
- R1: While reset is low and after it is released, `req_ready` is 1 and both `rd_valid` and `mem_req_valid` are 0 until a request is taken.
- R2: A request is accepted only in a cycle where `req_ready` is 1. `req_ready` falls on the next cycle, and a start request offered while it is 0 is ignored.
- R3: Line requests carry addresses with the low 5 bits zero. The first request is the line holding the start address, and each later request is the previous one plus 32. A request stays asserted with a stable address until `mem_req_ready` takes it.
- R4: A new line is requested only while fewer than two lines are held: lines requested minus lines fully drained to the bus is below 2. Up to two line fetches may be in flight, and each returns 8 words in address order through `mem_rsp_valid`.
- R5: Beats leave in ascending word order starting at word `req_addr[4:2]` of the first line. Earlier words of that line are never offered.
- R6: `rd_valid` is 1 exactly when the next word of the burst has been returned by memory, counting from the cycle after its `mem_rsp_valid` beat. Otherwise it is 0, which is a wait state.
- R7: A beat offered with `rd_ready` low stays offered on the next cycle with unchanged data, provided `rd_be` is unchanged and the burst is not ended.
- R8: Byte lane i of `rd_data` (bits 8i+7 down to 8i) carries the stored byte when `rd_be[i]` is 1 and reads 0 when it is 0.
- R9: When `req_end` is 1 during a burst, `rd_valid` and `mem_req_valid` are 0 from the next cycle. If no line fetch is in flight, `req_ready` returns on the next cycle. Otherwise it returns in the cycle after the last in-flight word has been absorbed.
- R10: With memory answering at one word per cycle without delay and the bus always ready, `rd_valid` stays 1 from the first beat to the end of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a burst read |
| req_ready | output | 1 | Block idle, start request accepted |
| req_addr | input | ADDR_W | Burst start byte address |
| req_end | input | 1 | End the current burst |
| rd_valid | output | 1 | Beat available |
| rd_ready | input | 1 | Bus takes the beat |
| rd_be | input | DATA_W/8 | Byte lanes applied to the beat |
| rd_data | output | DATA_W | Beat data, disabled lanes zero |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_ready | input | 1 | Memory takes the line request |
| mem_req_addr | output | ADDR_W | Line-aligned fetch address |
| mem_rsp_valid | input | 1 | One returned word |
| mem_rsp_data | input | DATA_W | Returned word |

## Verification
Some properties are checked on every cycle: the idle outputs are quiet, line addresses are aligned, and a pending line request is held. No more than one line's words are outstanding whenever a new request is raised. A stalled beat is held with the same data, disabled lanes read zero, and everything goes quiet after an end. Other behaviour shows only through the bench's scenarios: the beats come out in order from an unaligned start, a wait state appears exactly when a word is missing, streaming stays unbroken at full memory speed, and a burst ended with two lines still in flight drains before the block is idle again.

// File: rtl/pp_pkg.sv
package pp_pkg;
    typedef enum logic [1:0] {
        PP_IDLE   = 2'd0,
        PP_STREAM = 2'd1,
        PP_FLUSH  = 2'd2
    } pp_mode_e;
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
    parameter int DATA_W = 32,
    parameter int BEATS  = 8,
    localparam int IDX_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] words_q [BEATS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = words_q[rd_idx];
endmodule

// File: rtl/pp_beat_sel.sv
module pp_beat_sel #(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8
) (
    input  logic [1:0][DATA_W-1:0] words,
    input  logic                   sel,
    input  logic [BYTES-1:0]       be,
    output logic [DATA_W-1:0]      data
);
    logic [DATA_W-1:0] word;

    always_comb begin
        word = words[sel];
        for (int l = 0; l < BYTES; l++) begin
            data[l*8 +: 8] = be[l] ? word[l*8 +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
    import pp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int BEATS  = LINE_BYTES / BYTES,
    localparam int IDX_W  = $clog2(BEATS),
    localparam int CNT_W  = $clog2(BEATS + 1),
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              req_end,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic              rd_bank,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              mem_req_ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    output logic [1:0]        wr_en,
    output logic [IDX_W-1:0]  wr_idx
);
    typedef struct packed {
        pp_mode_e                mode;
        logic [ADDR_W-1:0]       next_line;
        logic                    rd_bank;
        logic [IDX_W-1:0]        rd_idx;
        logic                    rq_bank;
        logic                    fl_bank;
        logic [IDX_W-1:0]        fl_cnt;
        logic [1:0]              pend;
        logic [1:0]              inuse;
        logic [1:0][CNT_W-1:0]   cnt;
    } ctrl_st_t;

    ctrl_st_t st_q, st_d;

    logic rd_ok, rd_fire, mreq, mfire, rsp, line_done;
    logic unused_addr_lanes;

    assign unused_addr_lanes = ^req_addr[LANE_W-1:0];

    always_comb begin
        st_d = st_q;

        rd_ok     = (st_q.mode == PP_STREAM) && st_q.inuse[st_q.rd_bank]
                    && (st_q.cnt[st_q.rd_bank] > CNT_W'(st_q.rd_idx));
        rd_fire   = rd_ok && rd_ready;
        mreq      = (st_q.mode == PP_STREAM) && !st_q.inuse[st_q.rq_bank];
        mfire     = mreq && mem_req_ready;
        rsp       = (st_q.mode != PP_IDLE) && (st_q.pend != 2'd0) && mem_rsp_valid;
        line_done = rsp && (st_q.fl_cnt == IDX_W'(BEATS - 1));

        wr_en  = '0;
        wr_idx = st_q.fl_cnt;
        if (rsp && (st_q.mode == PP_STREAM)) begin
            wr_en[st_q.fl_bank] = 1'b1;
        end

        case (st_q.mode)
            PP_IDLE: begin
                if (req_valid) begin
                    st_d.mode      = PP_STREAM;
                    st_d.next_line = {req_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
                    st_d.rd_idx    = req_addr[OFF_W-1:LANE_W];
                    st_d.rd_bank   = 1'b0;
                    st_d.rq_bank   = 1'b0;
                    st_d.fl_bank   = 1'b0;
                    st_d.fl_cnt    = '0;
                    st_d.pend      = 2'd0;
                    st_d.inuse     = '0;
                    st_d.cnt       = '0;
                end
            end
            default: begin
                if (rsp) begin
                    if (st_q.mode == PP_STREAM) begin
                        st_d.cnt[st_q.fl_bank] = st_q.cnt[st_q.fl_bank] + CNT_W'(1);
                    end
                    if (line_done) begin
                        st_d.fl_cnt  = '0;
                        st_d.fl_bank = ~st_q.fl_bank;
                    end else begin
                        st_d.fl_cnt = st_q.fl_cnt + IDX_W'(1);
                    end
                end
                if (mfire) begin
                    st_d.inuse[st_q.rq_bank] = 1'b1;
                    st_d.rq_bank             = ~st_q.rq_bank;
                    st_d.next_line           = st_q.next_line + ADDR_W'(LINE_BYTES);
                end
                st_d.pend = st_q.pend + {1'b0, mfire} - {1'b0, line_done};
                if (rd_fire) begin
                    if (st_q.rd_idx == IDX_W'(BEATS - 1)) begin
                        st_d.rd_idx              = '0;
                        st_d.inuse[st_q.rd_bank] = 1'b0;
                        st_d.cnt[st_q.rd_bank]   = '0;
                        st_d.rd_bank             = ~st_q.rd_bank;
                    end else begin
                        st_d.rd_idx = st_q.rd_idx + IDX_W'(1);
                    end
                end
                if ((st_q.mode == PP_STREAM) && req_end) begin
                    st_d.inuse = '0;
                    st_d.cnt   = '0;
                    st_d.mode  = (st_d.pend != 2'd0) ? PP_FLUSH : PP_IDLE;
                end else if ((st_q.mode == PP_FLUSH) && (st_d.pend == 2'd0)) begin
                    st_d.mode = PP_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready     = (st_q.mode == PP_IDLE);
    assign rd_valid      = rd_ok;
    assign rd_bank       = st_q.rd_bank;
    assign rd_idx        = st_q.rd_idx;
    assign mem_req_valid = mreq;
    assign mem_req_addr  = st_q.next_line;
endmodule

// File: rtl/pp_prefetch_buf.sv
module pp_prefetch_buf #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int BEATS = LINE_BYTES / BYTES,
    localparam int IDX_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_end,
    output logic              rd_valid,
    input  logic              rd_ready,
    input  logic [BYTES-1:0]  rd_be,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    logic                   rd_bank;
    logic [IDX_W-1:0]       rd_idx;
    logic [1:0]             wr_en;
    logic [IDX_W-1:0]       wr_idx;
    logic [1:0][DATA_W-1:0] bank_word;

    pp_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .req_end(req_end),
        .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_bank(rd_bank), .rd_idx(rd_idx),
        .mem_req_ready(mem_req_ready), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .wr_en(wr_en), .wr_idx(wr_idx)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        pp_bank #(.DATA_W(DATA_W), .BEATS(BEATS)) u_bank (
            .clk(clk),
            .wr_en(wr_en[b]),
            .wr_idx(wr_idx),
            .wr_data(mem_rsp_data),
            .rd_idx(rd_idx),
            .rd_data(bank_word[b])
        );
    end

    pp_beat_sel #(.DATA_W(DATA_W)) u_sel (
        .words(bank_word),
        .sel(rd_bank),
        .be(rd_be),
        .data(rd_data)
    );
endmodule

// File: rtl/pp_prefetch_chk.sv
module pp_prefetch_chk #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int BEATS = LINE_BYTES / BYTES,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int PB_W  = $clog2(2 * BEATS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_end,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [BYTES-1:0]  rd_be,
    input logic [DATA_W-1:0] rd_data,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic [DATA_W-1:0] mem_rsp_data
);
    logic [PB_W-1:0]   pend_beats;
    logic [DATA_W-1:0] lane_mask;
    logic              unused_chk;

    assign unused_chk = req_valid ^ (^req_addr) ^ (^mem_rsp_data);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_beats <= '0;
        end else begin
            pend_beats <= pend_beats
                + ((mem_req_valid && mem_req_ready) ? PB_W'(BEATS) : PB_W'(0))
                - ((mem_rsp_valid && (pend_beats != '0)) ? PB_W'(1) : PB_W'(0));
        end
    end

    always_comb begin
        for (int l = 0; l < BYTES; l++) begin
            lane_mask[l*8 +: 8] = {8{rd_be[l]}};
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rd_valid && !mem_req_valid));

    assert_line_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && !req_end) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_two_line_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (pend_beats <= PB_W'(BEATS)));

    assert_valid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !req_end) |=> rd_valid);

    assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !req_end) |=> (!$stable(rd_be) || $stable(rd_data)));

    assert_lane_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data & ~lane_mask) == '0));

    assert_end_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && req_end) |=> (!rd_valid && !mem_req_valid));
endmodule

bind pp_prefetch_buf pp_prefetch_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)
) u_chk (.*);

// File: tb/pp_prefetch_buf_tb.sv
module pp_prefetch_buf_tb;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ready, req_end;
    logic [AW-1:0] req_addr;
    logic          rd_valid, rd_ready;
    logic [3:0]    rd_be;
    logic [DW-1:0] rd_data;
    logic          mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_rsp_data;

    always #4 clk = ~clk;

    pp_prefetch_buf u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_end(req_end),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_be(rd_be), .rd_data(rd_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int nchk = 0;
    int nerr = 0;
    // reference model state
    int m_mode = 0;
    logic [31:0] m_base = '0;
    int m_pos = 0, m_got = 0, m_lreq = 0, m_rlines = 0, m_fbeat = 0;
    // memory model
    logic [31:0] mq[$];
    int mbeat = 0, mwait = 0, lat = 0, gap_mode = 0, rdy_mode = 0;
    logic [31:0] lfsr = 32'h1D2C_3B4A;
    int nfire = 0, waits = 0;
    bit seen_first = 0;

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return (a * 32'h0100_0193) ^ 32'hC3A5_5A3C;
    endfunction

    function automatic logic [31:0] lanes(input logic [31:0] w, input logic [3:0] be);
        logic [31:0] r;
        for (int l = 0; l < 4; l++) r[l*8 +: 8] = be[l] ? w[l*8 +: 8] : 8'h00;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: entered and left at a falling edge
    task automatic cycle(input logic rv, input logic [31:0] ra, input logic re,
                         input logic rr, input logic [3:0] be);
        bit e_rr, e_rv, e_mv, f_rd, f_mq, f_rsp;
        logic [31:0] e_dat;
        e_rr = (m_mode == 0);
        e_rv = (m_mode == 1) && (m_pos < m_got);
        e_mv = (m_mode == 1) && ((m_lreq - m_pos / 8) < 2);
        chk(req_ready == e_rr, "R2 req_ready", 32'(req_ready), 32'(e_rr));
        chk(rd_valid == e_rv, "R6 rd_valid", 32'(rd_valid), 32'(e_rv));
        chk(mem_req_valid == e_mv, "R4 mem_req_valid", 32'(mem_req_valid), 32'(e_mv));
        if (e_mv) chk(mem_req_addr == m_base + 32'(m_lreq * 32), "R3 mem_req_addr",
                      mem_req_addr, m_base + 32'(m_lreq * 32));
        if (seen_first && !rd_valid && m_mode == 1) waits++;
        req_valid     = rv;
        req_addr      = ra;
        req_end       = re;
        rd_ready      = rr;
        rd_be         = be;
        mem_req_ready = (rdy_mode != 0) ? lfsr[0] : 1'b1;
        mem_rsp_valid = (mq.size() > 0 && mwait == 0) ? ((gap_mode != 0) ? lfsr[1] : 1'b1) : 1'b0;
        mem_rsp_data  = (mq.size() > 0) ? word_at(mq[0] + 32'(mbeat * 4)) : '0;
        #1;
        if (e_rv) begin
            e_dat = lanes(word_at(m_base + 32'(m_pos * 4)), be);
            if (be == 4'hF) chk(rd_data == e_dat, "R5 beat order", rd_data, e_dat);
            else            chk(rd_data == e_dat, "R8 byte lanes", rd_data, e_dat);
        end
        f_rd  = e_rv && rr;
        f_mq  = e_mv && mem_req_ready;
        f_rsp = mem_rsp_valid && (m_mode != 0);
        if (m_mode == 0) begin
            if (rv) begin
                m_mode = 1; m_base = ra & ~32'h1F; m_pos = int'((ra >> 2) & 32'h7);
                m_got = 0; m_lreq = 0; m_rlines = 0; m_fbeat = 0;
            end
        end else begin
            if (f_rsp) begin
                m_fbeat++;
                if (m_mode == 1) m_got++;
                if (m_fbeat == 8) begin m_fbeat = 0; m_rlines++; end
            end
            if (m_mode == 1 && f_mq) m_lreq++;
            if (f_rd) begin m_pos++; nfire++; seen_first = 1; end
            if (m_mode == 1 && re) m_mode = (m_lreq != m_rlines) ? 2 : 0;
            else if (m_mode == 2 && m_lreq == m_rlines) m_mode = 0;
        end
        if (f_rsp) begin
            mbeat++;
            if (mbeat == 8) begin void'(mq.pop_front()); mbeat = 0; mwait = lat; end
        end else if (mq.size() > 0 && mwait > 0) mwait--;
        if (f_mq) begin
            if (mq.size() == 0) mwait = lat;
            mq.push_back(mem_req_addr);
        end
        lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic burst(input logic [31:0] addr, input int nbeats, input int stall,
                         input bit rand_be, input bit poke_flush);
        int guard;
        logic rr;
        logic [3:0] be;
        while (m_mode != 0) cycle(1'b0, '0, 1'b0, 1'b1, 4'hF);
        cycle(1'b1, addr, 1'b0, 1'b1, 4'hF);
        nfire = 0; waits = 0; seen_first = 0; guard = 0;
        while (nfire < nbeats && guard < 5000) begin
            rr = (stall == 0) ? 1'b1 : ((stall == 1) ? lfsr[2] : (lfsr[2] & lfsr[5]));
            be = rand_be ? lfsr[7:4] : 4'hF;
            cycle(1'b0, '0, 1'b0, rr, be);
            guard++;
        end
        cycle(1'b0, '0, 1'b1, 1'b1, 4'hF);
        seen_first = 0;
        guard = 0;
        while (m_mode != 0 && guard < 5000) begin
            cycle(poke_flush, addr + 32'h100, 1'b0, 1'b1, 4'hF);
            guard++;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL R6 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 0; req_addr = '0; req_end = 0; rd_ready = 0; rd_be = 4'hF;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset req_ready", 32'(req_ready), 32'd1);
        chk(rd_valid == 1'b0 && mem_req_valid == 1'b0, "R1 reset outputs",
            32'({rd_valid, mem_req_valid}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !rd_valid && !mem_req_valid, "R1 after release",
            32'({req_ready, rd_valid, mem_req_valid}), 32'd4);
        // R10: full-speed memory, always-ready bus, aligned start
        lat = 0; gap_mode = 0; rdy_mode = 0;
        burst(32'h0000_1000, 40, 0, 1'b0, 1'b0);
        chk(waits == 0, "R10 continuous stream", 32'(waits), 32'd0);
        // R5/R6: unaligned start, slow and gappy memory, random bus stalls and lanes (R8)
        lat = 5; gap_mode = 1; rdy_mode = 1;
        burst(32'h0000_2014, 30, 1, 1'b1, 1'b0);
        // R4/R7: slow bus holds both banks, prefetch must stop at two lines
        lat = 0; gap_mode = 0; rdy_mode = 0;
        burst(32'h0000_3FE0, 24, 2, 1'b1, 1'b0);
        // R9/R2: end early with two long fetches in flight, start attempts while draining
        lat = 12; gap_mode = 0; rdy_mode = 0;
        burst(32'h0000_4008, 3, 0, 1'b0, 1'b1);
        // R9: end at once after the start
        lat = 3; gap_mode = 1; rdy_mode = 1;
        burst(32'h0000_5000, 0, 0, 1'b0, 1'b1);
        // back-to-back short bursts at line ends
        lat = 1; gap_mode = 1; rdy_mode = 0;
        burst(32'h0000_601C, 9, 1, 1'b1, 1'b0);
        burst(32'h0000_7000, 16, 0, 1'b0, 1'b0);
        repeat (3) cycle(1'b0, '0, 1'b0, 1'b1, 4'hF);
        chk(req_ready == 1'b1 && !rd_valid, "R9 idle at end",
            32'({req_ready, rd_valid}), 32'd2);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule